// File: doc/BRIEF.md
# Dual-clock line delay memory

A byte-wide line store of 5120 words with two independent ports. The write port has its own clock, an active-low enable and an active-low pointer clear. On every enabled rising write-clock edge it stores the input byte at its current address and moves the address on by one. The read port has its own clock, enable and pointer clear. On every enabled rising read-clock edge it registers the word at its current address onto the output, raises the output-enable and moves its address on by one.

There are no occupancy flags and no pointer exchange between the clock domains. The time at which each port's pointer is cleared alone sets the distance between writer and reader. With both ports running at one line rate, clearing the read pointer N edges after the write pointer gives an N-word delay line. The tri-state output is modelled as a data bus plus an output-enable. Both pointer clears must be applied after power-up. Stored words are expected to be read back within about 20 ms, and the model does not refresh them.

Top module: `line_mem`

## Requirements
- R1: When `we_ni` is 0 and `wrst_ni` is 1 at a rising `wclk_i` edge, `wdata_i` is stored at the write address, and the write address then advances by one.
- R2: When `we_ni` is 1 at a rising `wclk_i` edge, no word is stored and the write address keeps its value.
- R3: When `wrst_ni` is 0 at a rising `wclk_i` edge, the write address is cleared. If `we_ni` is also 0 on that edge, the word goes to address 0 and the next write uses address 1.
- R4: When `re_ni` is 0 and `rrst_ni` is 1 at a rising `rclk_i` edge, the word at the read address appears on `rdata_o` after that edge, `oe_o` is 1, and the read address advances by one.
- R5: When `re_ni` is 1 at a rising `rclk_i` edge, `oe_o` is 0 after that edge, `rdata_o` keeps its previous value and the read address keeps its value.
- R6: When `rrst_ni` is 0 at a rising `rclk_i` edge, the read address is cleared. If `re_ni` is also 0 on that edge, address 0 is read and the next read uses address 1.
- R7: Both addresses count through 0 to 5119 and wrap from 5119 to 0.
- R8: When a read and a write hit the same address on the same clock edge, the read returns the word stored before that edge. The new word is returned by a later read of that address.
- R9: While `rst_ni` is 0, both addresses are 0, `oe_o` is 0 and `rdata_o` is 0. This takes effect without a clock edge.
- R10: With both clocks at the same rate, clearing the read pointer N edges after the write pointer, and enabling both ports on every edge, makes `rdata_o` repeat `wdata_i` delayed by N edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset of both pointers and the output register |
| wclk_i | input | 1 | Write clock |
| we_ni | input | 1 | Write enable, active low |
| wrst_ni | input | 1 | Write pointer clear, active low, synchronous to `wclk_i` |
| wdata_i | input | 8 | Write data |
| rclk_i | input | 1 | Read clock |
| re_ni | input | 1 | Read enable, active low |
| rrst_ni | input | 1 | Read pointer clear, active low, synchronous to `rclk_i` |
| rdata_o | output | 8 | Read data |
| oe_o | output | 1 | Output enable. When it is 0, the bus is taken as high impedance |

## Verification
The hardest cases to reach from the ports are the pointer wrap and the same-edge collision of reader and writer. The wrap needs more than 5120 consecutive enabled writes and reads before address 0 is overwritten and read again. The collision needs both pointers cleared on one edge, so that every following access meets at the same address. The stimulus fills the whole line plus three words and then reads it all back. It also fills a short span with one pattern, clears both pointers together and writes a second pattern while reading, so that the reads must return the first pattern.

// File: rtl/lm_pkg.sv
package lm_pkg;

  localparam int unsigned LM_DEPTH = 5120;
  localparam int unsigned LM_WIDTH = 8;

  typedef enum logic [1:0] {
    PTR_HOLD,
    PTR_STEP,
    PTR_ZERO,
    PTR_ONE
  } ptr_op_e;

  // clear wins over enable; a cleared access uses address 0
  function automatic ptr_op_e ptr_op(input logic clr_n, input logic en_n);
    if (!clr_n) return en_n ? PTR_ZERO : PTR_ONE;
    if (!en_n)  return PTR_STEP;
    return PTR_HOLD;
  endfunction

endpackage

// File: rtl/lm_ptr.sv
module lm_ptr #(
  parameter int unsigned DEPTH = lm_pkg::LM_DEPTH,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  logic          en_ni,
  output logic [AW-1:0] acc_o,
  output logic [AW-1:0] cnt_o
);
  import lm_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] cnt_q;
  ptr_op_e       op;

  assign op    = ptr_op(clr_ni, en_ni);
  assign acc_o = clr_ni ? cnt_q : '0;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case (op)
        PTR_ZERO: cnt_q <= '0;
        PTR_ONE:  cnt_q <= AW'(1);
        PTR_STEP: cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + AW'(1);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/lm_mem.sv
module lm_mem #(
  parameter int unsigned DEPTH = lm_pkg::LM_DEPTH,
  parameter int unsigned WIDTH = lm_pkg::LM_WIDTH,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rword_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // sampled by the read register at its edge: old word on collision
  assign rword_o = mem_q[raddr_i];

endmodule

// File: rtl/lm_rd_out.sv
module lm_rd_out #(
  parameter int unsigned WIDTH = lm_pkg::LM_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_ni,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] data_o,
  output logic             oe_o
);

  logic [WIDTH-1:0] data_q;
  logic             oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= ~en_ni;
      if (!en_ni) data_q <= word_i;
    end
  end

  assign data_o = data_q;
  assign oe_o   = oe_q;

endmodule

// File: rtl/line_mem.sv
module line_mem #(
  parameter int unsigned DEPTH = lm_pkg::LM_DEPTH,
  parameter int unsigned WIDTH = lm_pkg::LM_WIDTH
) (
  input  logic             rst_ni,
  input  logic             wclk_i,
  input  logic             we_ni,
  input  logic             wrst_ni,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rclk_i,
  input  logic             re_ni,
  input  logic             rrst_ni,
  output logic [WIDTH-1:0] rdata_o,
  output logic             oe_o
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [AW-1:0]    wacc, waddr;
  logic [AW-1:0]    racc, raddr;
  logic [WIDTH-1:0] rword;

  lm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .clr_ni (wrst_ni),
    .en_ni  (we_ni),
    .acc_o  (wacc),
    .cnt_o  (waddr)
  );

  lm_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .clr_ni (rrst_ni),
    .en_ni  (re_ni),
    .acc_o  (racc),
    .cnt_o  (raddr)
  );

  lm_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (~we_ni),
    .waddr_i (wacc),
    .wdata_i (wdata_i),
    .raddr_i (racc),
    .rword_o (rword)
  );

  lm_rd_out #(.WIDTH(WIDTH)) u_rout (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .en_ni  (re_ni),
    .word_i (rword),
    .data_o (rdata_o),
    .oe_o   (oe_o)
  );

endmodule

// File: rtl/lm_chk.sv
module lm_chk #(
  parameter int unsigned DEPTH = lm_pkg::LM_DEPTH,
  parameter int unsigned WIDTH = lm_pkg::LM_WIDTH,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input logic             rst_ni,
  input logic             wclk_i,
  input logic             we_ni,
  input logic             wrst_ni,
  input logic             rclk_i,
  input logic             re_ni,
  input logic             rrst_ni,
  input logic [AW-1:0]    waddr_i,
  input logic [AW-1:0]    raddr_i,
  input logic [WIDTH-1:0] rdata_i,
  input logic             oe_i
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R1
  wr_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wrst_ni && !we_ni && waddr_i != LAST) |=> waddr_i == $past(waddr_i) + AW'(1));

  // R2
  wr_hold_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wrst_ni && we_ni) |=> $stable(waddr_i));

  // R3
  wr_clr_idle_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wrst_ni && we_ni) |=> waddr_i == '0);

  // R3
  wr_clr_acc_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wrst_ni && !we_ni) |=> waddr_i == AW'(1));

  // R4
  rd_oe_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !re_ni |=> oe_i);

  // R4
  rd_step_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rrst_ni && !re_ni && raddr_i != LAST) |=> raddr_i == $past(raddr_i) + AW'(1));

  // R5
  rd_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    re_ni |=> (!oe_i && $stable(rdata_i) && $stable(raddr_i)));

  // R6
  rd_clr_acc_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rrst_ni && !re_ni) |=> raddr_i == AW'(1));

  // R7
  wr_wrap_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wrst_ni && !we_ni && waddr_i == LAST) |=> waddr_i == '0);

  // R7
  rd_wrap_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rrst_ni && !re_ni && raddr_i == LAST) |=> raddr_i == '0);

  // R7
  range_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (waddr_i <= LAST && raddr_i <= LAST));

  // R9
  rst_state_chk: assert property (@(posedge rclk_i)
    !rst_ni |-> (waddr_i == '0 && raddr_i == '0 && !oe_i && rdata_i == '0));

endmodule

bind line_mem lm_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .rst_ni  (rst_ni),
  .wclk_i  (wclk_i),
  .we_ni   (we_ni),
  .wrst_ni (wrst_ni),
  .rclk_i  (rclk_i),
  .re_ni   (re_ni),
  .rrst_ni (rrst_ni),
  .waddr_i (waddr),
  .raddr_i (raddr),
  .rdata_i (rdata_o),
  .oe_i    (oe_o)
);

// File: tb/tb_line_mem.sv
module tb_line_mem;

  localparam int DEPTH = 5120;

  logic       rst_ni = 1'b1;
  logic       wclk = 1'b0, rclk = 1'b0;
  logic       we_ni = 1'b1, wrst_ni = 1'b1, re_ni = 1'b1, rrst_ni = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       oe;

  line_mem dut (
    .rst_ni  (rst_ni),
    .wclk_i  (wclk),
    .we_ni   (we_ni),
    .wrst_ni (wrst_ni),
    .wdata_i (wdata),
    .rclk_i  (rclk),
    .re_ni   (re_ni),
    .rrst_ni (rrst_ni),
    .rdata_o (rdata),
    .oe_o    (oe)
  );

  // 50 MHz, both ports on the same rate and phase
  always #10 begin
    wclk = ~wclk;
    rclk = ~rclk;
  end

  typedef struct {
    logic       oe;
    logic [7:0] d;
    string      tag;
  } exp_t;

  exp_t       sb_q[$];
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  logic [7:0] mdl [DEPTH];
  int         mwa = 0, mra = 0;
  logic [7:0] last_d = '0;
  logic       last_oe = 1'b0;

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: oe/data actual %b/%h expected %b/%h", tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // one edge on both ports; model updates read before write (R8)
  task automatic step(input bit wen, input bit wclr, input logic [7:0] wd,
                      input bit ren, input bit rclr, input string tag);
    int a;
    @(negedge wclk);
    we_ni = ~wen; wrst_ni = ~wclr; wdata = wd;
    re_ni = ~ren; rrst_ni = ~rclr;
    @(posedge wclk); #1;
    if (ren) begin
      a = rclr ? 0 : mra;
      last_d = mdl[a];
      last_oe = 1'b1;
    end else last_oe = 1'b0;
    if (rclr) mra = ren ? 1 : 0;
    else if (ren) mra = (mra == DEPTH-1) ? 0 : mra + 1;
    if (wen) begin
      a = wclr ? 0 : mwa;
      mdl[a] = wd;
    end
    if (wclr) mwa = wen ? 1 : 0;
    else if (wen) mwa = (mwa == DEPTH-1) ? 0 : mwa + 1;
    sb_q.push_back('{last_oe, last_d, tag});
  endtask

  task automatic idle(input string tag);
    step(0, 0, 8'h00, 0, 0, tag);
  endtask

  // monitor
  always @(negedge wclk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, {oe, rdata}, {e.oe, e.d});
    end
  end

  task automatic do_reset();
    @(negedge wclk);
    rst_ni = 1'b0;
    #3;
    // R9: outputs clear without a clock edge
    check("R9", {oe, rdata}, 9'h000);
    @(negedge wclk);
    @(negedge wclk);
    check("R9", {oe, rdata}, 9'h000);
    rst_ni = 1'b1;
    mwa = 0; mra = 0; last_d = '0; last_oe = 1'b0;
  endtask

  initial begin
    #2 rst_ni = 1'b0;
    @(negedge wclk);
    check("R9", {oe, rdata}, 9'h000);
    @(negedge wclk);
    rst_ni = 1'b1;

    // R3 clear with coincident write, R1 writes
    step(1, 1, 8'h10, 0, 0, "R3");
    for (int i = 1; i < 16; i++) step(1, 0, 8'(8'h10 + i), 0, 0, "R1");
    // R2: disabled writes with junk data
    for (int i = 0; i < 3; i++) step(0, 0, 8'hEE, 0, 0, "R2");
    for (int i = 0; i < 4; i++) step(1, 0, 8'(8'h20 + i), 0, 0, "R1");
    idle("R5");

    // R6 clear with coincident read, R4 reads, R5 pauses
    step(0, 0, 8'h00, 1, 1, "R6");
    for (int i = 1; i < 24; i++) begin
      if (i % 5 == 0) step(0, 0, 8'h00, 0, 0, "R5");
      else            step(0, 0, 8'h00, 1, 0, "R4");
    end
    idle("R5");

    // R8: both pointers cleared together, reads meet writes
    for (int i = 0; i < 8; i++) step(1, i == 0, 8'(8'hA0 + i), 0, 0, "R8");
    for (int i = 0; i < 8; i++) step(1, i == 0, 8'(8'hB0 + i), 1, i == 0, "R8");
    for (int i = 0; i < 8; i++) step(0, 0, 8'h00, 1, i == 0, "R8");
    idle("R5");

    // R10: delay line of 6 edges
    for (int i = 0; i < 6; i++) step(1, i == 0, 8'(8'h40 + 7*i), 0, 0, "R10");
    for (int i = 6; i < 30; i++) step(1, 0, 8'(8'h40 + 7*i), 1, i == 6, "R10");
    idle("R5");

    // R7: fill past the end, then read everything back
    for (int i = 0; i < DEPTH + 3; i++) step(1, i == 0, 8'(i ^ (i >> 8) ^ 8'h5A), 0, 0, "R7");
    for (int i = 0; i < DEPTH + 3; i++) step(0, 0, 8'h00, 1, i == 0, "R7");
    idle("R5");

    // R9: asynchronous reset mid-run clears the read pointer
    @(negedge wclk);
    do_reset();
    step(0, 0, 8'h00, 1, 0, "R9");
    step(0, 0, 8'h00, 1, 0, "R9");
    idle("R5");
    @(negedge wclk);
    @(negedge wclk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule